// File: doc/BRIEF.md
# Precise Exception Capture Unit

This block sits beside the memory stage of a pipelined processor and records what is needed to restart an instruction that faulted on a memory access. Each cycle it looks at the memory stage's valid flag, instruction address, store write enable and three fault lines. These lines report a missing translation, a non-resident page and a write to a read-only page. When a fault is accepted, the unit saves the instruction address and a cause code. It then masks further exceptions and sends fetch to a fixed handler address. A faulting store never reaches memory, so the instruction can be run again cleanly.

The handler ends with a return request. That request sends fetch back to the saved address and lifts the mask. Faults that arrive while the mask is set go into a one-entry holding slot. The slot is taken as soon as the mask clears, so the saved restart address is never overwritten by a later event.

Top module: `exc_capture`

## Requirements
- R1: After reset the saved address and cause read zero, the mask flag is clear and no redirect is signalled.
- R2: When a fault is accepted, the saved address holds the faulting instruction's address from the next cycle on, and the mask flag is set.
- R3: Cause codes are 1 for a translation miss, 2 for a page fault and 3 for a write-protection violation. When several fault lines are high together, the page fault wins over the protection violation, which wins over the miss. A set mask flag always comes with a non-zero cause.
- R4: In the cycle after a fault is accepted, the redirect strobe is high for exactly one cycle with the handler address.
- R5: In any cycle where the memory stage is valid and a fault line is high, the data write enable output is low in that same cycle. Otherwise it follows the stage's write enable.
- R6: While the mask flag is set, new faults change neither the saved address nor the cause.
- R7: The first fault that arrives while masked is held in one slot and taken in the cycle after the mask clears. Later faults that arrive while the slot is full are dropped.
- R8: A return request while masked causes a one-cycle redirect to the saved address on the next cycle and clears the mask.
- R9: A return request while unmasked is ignored: no redirect is made and the mask stays clear.
- R10: Fault lines are ignored when the memory stage is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_valid | input | 1 | Memory stage holds a live instruction |
| mem_pc | input | PC_W | Address of that instruction |
| mem_we | input | 1 | Stage's data write enable (store) |
| flt_tmiss | input | 1 | Translation miss |
| flt_pfault | input | 1 | Page not resident |
| flt_wprot | input | 1 | Write to a read-only page |
| eret | input | 1 | Return from handler |
| dmem_we | output | 1 | Gated data-memory write enable |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | PC_W | Redirect target |
| epc | output | PC_W | Saved restart address |
| cause | output | 2 | Saved cause code |
| exc_disabled | output | 1 | Exceptions masked |

## Verification
Stores are driven with no fault, with a fault while the stage is idle, and with a page fault. Together these show write gating, the valid qualifier and the acceptance path. Faults then arrive while masked, one to fill the holding slot and one against a full slot. This shows that held faults are taken after the return and that overflow faults are dropped. Combined fault lines check the cause priority. A return with no open exception checks that such requests have no effect, and a scoreboard matches every redirect against the expected target in order.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_TMISS  = 2'd1,
        CAUSE_PFAULT = 2'd2,
        CAUSE_WPROT  = 2'd3
    } cause_e;
endpackage

// File: rtl/exc_cause_enc.sv
module exc_cause_enc
    import exc_pkg::*;
(
    input  logic   valid,
    input  logic   tmiss,
    input  logic   pfault,
    input  logic   wprot,
    output cause_e code,
    output logic   hit
);
    always_comb begin
        code = CAUSE_NONE;
        if (valid) begin
            if (pfault)     code = CAUSE_PFAULT;
            else if (wprot) code = CAUSE_WPROT;
            else if (tmiss) code = CAUSE_TMISS;
        end
        hit = (code != CAUSE_NONE);
    end
endmodule

// File: rtl/exc_wr_gate.sv
module exc_wr_gate (
    input  logic we_in,
    input  logic fault_hit,
    output logic we_out
);
    always_comb begin
        we_out = we_in && !fault_hit;
    end
endmodule

// File: rtl/exc_capture.sv
module exc_capture
    import exc_pkg::*;
#(
    parameter int          PC_W        = 32,
    parameter logic [31:0] HANDLER_VEC = 32'h8000_0080
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mem_valid,
    input  logic [PC_W-1:0] mem_pc,
    input  logic            mem_we,
    input  logic            flt_tmiss,
    input  logic            flt_pfault,
    input  logic            flt_wprot,
    input  logic            eret,
    output logic            dmem_we,
    output logic            redirect_valid,
    output logic [PC_W-1:0] redirect_pc,
    output logic [PC_W-1:0] epc,
    output logic [1:0]      cause,
    output logic            exc_disabled
);
    localparam logic [PC_W-1:0] VEC = HANDLER_VEC[PC_W-1:0];

    typedef struct packed {
        logic [PC_W-1:0] epc;
        cause_e          cause;
        logic            dis;
        logic            pend_v;
        logic [PC_W-1:0] pend_pc;
        cause_e          pend_cause;
        logic            rdr_v;
        logic [PC_W-1:0] rdr_pc;
    } state_t;

    state_t q, d;
    cause_e fault_code;
    logic   fault_hit;
    logic   pend_v;

    exc_cause_enc u_enc (
        .valid  (mem_valid),
        .tmiss  (flt_tmiss),
        .pfault (flt_pfault),
        .wprot  (flt_wprot),
        .code   (fault_code),
        .hit    (fault_hit)
    );

    exc_wr_gate u_gate (
        .we_in     (mem_we),
        .fault_hit (fault_hit),
        .we_out    (dmem_we)
    );

    always_comb begin
        d       = q;
        d.rdr_v = 1'b0;
        if (!q.dis) begin
            if (q.pend_v) begin
                d.epc        = q.pend_pc;
                d.cause      = q.pend_cause;
                d.dis        = 1'b1;
                d.rdr_v      = 1'b1;
                d.rdr_pc     = VEC;
                d.pend_v     = fault_hit;
                d.pend_pc    = mem_pc;
                d.pend_cause = fault_code;
            end else if (fault_hit) begin
                d.epc    = mem_pc;
                d.cause  = fault_code;
                d.dis    = 1'b1;
                d.rdr_v  = 1'b1;
                d.rdr_pc = VEC;
            end
        end else begin
            if (fault_hit && !q.pend_v) begin
                d.pend_v     = 1'b1;
                d.pend_pc    = mem_pc;
                d.pend_cause = fault_code;
            end
            if (eret) begin
                d.dis    = 1'b0;
                d.rdr_v  = 1'b1;
                d.rdr_pc = q.epc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{epc: '0, cause: CAUSE_NONE, dis: 1'b0, pend_v: 1'b0,
                   pend_pc: '0, pend_cause: CAUSE_NONE, rdr_v: 1'b0, rdr_pc: '0};
        end else begin
            q <= d;
        end
    end

    assign pend_v         = q.pend_v;
    assign redirect_valid = q.rdr_v;
    assign redirect_pc    = q.rdr_pc;
    assign epc            = q.epc;
    assign cause          = q.cause;
    assign exc_disabled   = q.dis;
endmodule

// File: rtl/exc_capture_chk.sv
module exc_capture_chk #(
    parameter int          PC_W        = 32,
    parameter logic [31:0] HANDLER_VEC = 32'h8000_0080
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_valid,
    input logic [PC_W-1:0] mem_pc,
    input logic            flt_tmiss,
    input logic            flt_pfault,
    input logic            flt_wprot,
    input logic            eret,
    input logic            dmem_we,
    input logic            redirect_valid,
    input logic [PC_W-1:0] redirect_pc,
    input logic [PC_W-1:0] epc,
    input logic [1:0]      cause,
    input logic            exc_disabled,
    input logic            pend_v
);
    logic any_flt;
    assign any_flt = mem_valid && (flt_tmiss || flt_pfault || flt_wprot);

    AST_STORE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        any_flt |-> !dmem_we); // R5
    AST_EPC_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_disabled && !pend_v && any_flt) |=> (epc == $past(mem_pc)) && exc_disabled); // R2
    AST_VECTOR_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_disabled && !pend_v && any_flt) |=> redirect_valid && (redirect_pc == HANDLER_VEC[PC_W-1:0])); // R4
    AST_HOLD_WHILE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_disabled && !eret) |=> exc_disabled && $stable(epc) && $stable(cause)); // R6
    AST_ERET_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_disabled && eret) |=> redirect_valid && (redirect_pc == $past(epc)) && !exc_disabled); // R8
    AST_ERET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_disabled && !pend_v && eret && !any_flt) |=> !redirect_valid && !exc_disabled); // R9
    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        exc_disabled |-> (cause != 2'd0)); // R3
endmodule

bind exc_capture exc_capture_chk #(.PC_W(PC_W), .HANDLER_VEC(HANDLER_VEC)) u_chk (.*);

// File: tb/tb_exc_capture.sv
module tb_exc_capture;
    localparam int          PC_W = 32;
    localparam logic [31:0] VEC  = 32'h8000_0080;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mem_valid = 1'b0;
    logic [PC_W-1:0] mem_pc = '0;
    logic            mem_we = 1'b0;
    logic            flt_tmiss = 1'b0, flt_pfault = 1'b0, flt_wprot = 1'b0;
    logic            eret = 1'b0;
    logic            dmem_we, redirect_valid, exc_disabled;
    logic [PC_W-1:0] redirect_pc, epc;
    logic [1:0]      cause;

    int checks = 0;
    int failures = 0;
    logic [PC_W-1:0] exp_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    exc_capture #(.PC_W(PC_W), .HANDLER_VEC(VEC)) dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at negedge, observe 1 time unit after the next rising edge
    task automatic step(input bit v, input logic [PC_W-1:0] pc, input bit we,
                        input bit tm, input bit pf, input bit wp, input bit er);
        @(negedge clk);
        mem_valid = v; mem_pc = pc; mem_we = we;
        flt_tmiss = tm; flt_pfault = pf; flt_wprot = wp; eret = er;
        #1;
        if (we) chk(dmem_we == !(v && (tm || pf || wp)), "R5 write gate", dmem_we, !(v && (tm || pf || wp)));
        @(posedge clk);
        #1;
        mem_valid = 0; mem_we = 0; flt_tmiss = 0; flt_pfault = 0; flt_wprot = 0; eret = 0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && redirect_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected redirect", redirect_pc, 0);
                end else begin
                    logic [PC_W-1:0] e;
                    e = exp_q.pop_front();
                    chk(redirect_pc == e, "R4/R8 redirect target", redirect_pc, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(epc == 0, "R1 epc reset", epc, 0);
        chk(cause == 0, "R1 cause reset", cause, 0);
        chk(!exc_disabled, "R1 mask reset", exc_disabled, 0);
        chk(!redirect_valid, "R1 redirect reset", redirect_valid, 0);
        @(negedge clk); rst_n = 1'b1;

        step(1, 32'h40, 1, 0, 0, 0, 0);          // clean store, R5
        chk(!exc_disabled, "R5 no fault no mask", exc_disabled, 0);
        step(0, 32'h44, 1, 0, 1, 0, 0);          // R10 fault without valid
        chk(!exc_disabled, "R10 idle fault ignored", exc_disabled, 0);
        chk(epc == 0, "R10 epc untouched", epc, 0);

        exp_q.push_back(VEC);
        step(1, 32'h100, 1, 0, 1, 0, 0);         // page fault on store
        chk(epc == 32'h100, "R2 epc latch", epc, 32'h100);
        chk(cause == 2, "R3 page fault code", cause, 2);
        chk(exc_disabled, "R2 mask set", exc_disabled, 1);

        step(1, 32'h200, 1, 1, 0, 0, 0);         // held in slot
        chk(epc == 32'h100, "R6 epc held", epc, 32'h100);
        chk(cause == 2, "R6 cause held", cause, 2);
        chk(!redirect_valid, "R4 single pulse", redirect_valid, 0);
        step(1, 32'h300, 0, 0, 0, 1, 0);         // slot full, dropped
        chk(epc == 32'h100, "R6 epc held 2", epc, 32'h100);

        exp_q.push_back(32'h100);
        exp_q.push_back(VEC);
        step(0, 0, 0, 0, 0, 0, 1);               // return
        chk(!exc_disabled, "R8 mask cleared", exc_disabled, 0);
        step(0, 0, 0, 0, 0, 0, 0);               // pending taken
        chk(epc == 32'h200, "R7 pending epc", epc, 32'h200);
        chk(cause == 1, "R7 pending cause tmiss", cause, 1);
        chk(exc_disabled, "R7 mask set again", exc_disabled, 1);

        exp_q.push_back(32'h200);
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        chk(!exc_disabled, "R7 dropped fault not taken", exc_disabled, 0);
        chk(epc == 32'h200, "R7 epc after drop", epc, 32'h200);

        step(0, 0, 0, 0, 0, 0, 1);               // stray return
        chk(!redirect_valid, "R9 stray return", redirect_valid, 0);
        chk(!exc_disabled, "R9 mask stays clear", exc_disabled, 0);

        exp_q.push_back(VEC);
        step(1, 32'h500, 0, 1, 1, 1, 0);
        chk(cause == 2, "R3 pfault priority", cause, 2);
        exp_q.push_back(32'h500);
        step(0, 0, 0, 0, 0, 0, 1);

        exp_q.push_back(VEC);
        step(1, 32'h600, 1, 1, 0, 1, 0);
        chk(cause == 3, "R3 wprot over tmiss", cause, 3);
        chk(epc == 32'h600, "R2 epc second", epc, 32'h600);
        exp_q.push_back(32'h600);
        step(0, 0, 0, 0, 0, 0, 1);

        exp_q.push_back(VEC);
        step(1, 32'h700, 0, 1, 0, 0, 0);
        chk(cause == 1, "R3 tmiss alone", cause, 1);
        exp_q.push_back(32'h700);
        step(0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0);

        chk(exp_q.size() == 0, "R4 all redirects seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule